// File: doc/BRIEF.md
# Receive Alarm Sticky Interrupt Status Word

This block gathers sixteen receive-side alarm and event sources of a T1 framer into one 16-bit sticky status word and raises a single interrupt line while any bit of that word is set. The upper byte reports the wrap of eight 8-bit error counters. The block keeps an 8-bit shadow count for each counter and sees only the counters' increment strobes. The lower byte reports:

- changes of the terminal-frame and multiframe sync levels;
- framing-bit errors while in terminal frame sync;
- a change of frame alignment after a reframe;
- a severely errored frame, found by a 2-of-6 framing-error window;
- AIS, local CRC-6 error and loss of signal pulses.

Each source has its own enable bit in `irq_mask`, where 1 lets the source through. A set bit stays set until the host reads the word. The word answers at two register addresses that alias each other, and a read strobe to either one clears the word. Sources are sampled on the rising clock edge, so a status bit is visible one cycle after the input that caused it.

Top module: `rx_alarm_irq_status`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `status` is 0 and `irq` is 0. Reset also clears the shadow counts, the framing-error history, the stored alignment (0) and the stored sync levels (0).
- R2: Bit 8+i of `status` sets when `cnt_inc[i]` pulses while shadow count i is 0xFF, which wraps it to 0x00. Each of the first 255 strobes after reset leaves the bit clear. Index 7 is framing-bit errors, 6 CRC-6 errors, 5 out-of-frame, 4 alignment changes, 3 bipolar violations, 2 PRBS errors, 1 PRBS multiframes, 0 multiframes out of sync.
- R3: Bit 7 sets when `tfs_lvl` differs from its value on the previous cycle, in either direction. Bit 6 does the same for `mfs_lvl`. A steady level sets nothing.
- R4: Bit 5 sets on a cycle with `fbit_valid` and `fbit_err` both high, but only if `tfs_lvl` is high on that cycle. With `tfs_lvl` low, bit 5 stays 0.
- R5: Bit 4 sets when `reframe_done` pulses with a `new_align` different from the alignment stored at the last reframe. A reframe to the same alignment sets nothing, and every reframe stores its alignment.
- R6: Bit 3 sets when a framing bit in error (`fbit_valid` and `fbit_err`) arrives while at least one of the five framing bits before it was in error. That makes two errors within six framing bits. An error with the five bits before it all clean does not set bit 3.
- R7: Bit 2 sets on `ais_pulse`, bit 1 on `crc_err_pulse` and bit 0 on `los_pulse`.
- R8: A source whose `irq_mask` bit is 0 never sets its status bit. An event that occurs while masked is lost and does not appear when the bit is later unmasked.
- R9: A set status bit stays set on every cycle until a clearing read.
- R10: A cycle with `rd_en` high and `rd_addr` equal to 0x34 or 0x24 clears the whole word at that edge. A read at any other address leaves `status` unchanged.
- R11: An unmasked event in the same cycle as a clearing read wins: its bit is set after the clear.
- R12: `irq` is high exactly when at least one `status` bit is set. It is active high and falls together with the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_inc | input | 8 | Increment strobes of the eight error counters (index map in R2) |
| tfs_lvl | input | 1 | Terminal frame sync level, 1 = in sync |
| mfs_lvl | input | 1 | Multiframe sync level, 1 = in sync |
| fbit_valid | input | 1 | One cycle per received framing bit |
| fbit_err | input | 1 | That framing bit was wrong; qualified by `fbit_valid` |
| reframe_done | input | 1 | Pulse when a reframe has finished |
| new_align | input | 8 | Frame alignment found by the finished reframe |
| ais_pulse | input | 1 | All-ones receive condition event |
| crc_err_pulse | input | 1 | Local CRC-6 error event |
| los_pulse | input | 1 | Loss of signal event |
| irq_mask | input | 16 | Per-bit enable, 1 = unmasked |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address |
| status | output | 16 | Sticky interrupt status word |
| irq | output | 1 | Interrupt, OR of all status bits |

## Verification
The bench drives 255 strobes into a counter and then the 256th. A design that flagged any increment, or flagged its wrap one strobe early, sets the overflow bit too soon. It flips the sync levels both ways; a design that caught only rising edges misses the loss-of-sync report. The severely-errored-frame window is probed with errors four and five clean bits apart: an off-by-one history length flags the wider pair or misses the narrower one. Clearing reads are issued together with events and at a non-aliased address. A design that let the clear win would lose the event, and a loose address compare would wipe the word.

// File: rtl/rx_alarm_irq_pkg.sv
package rx_alarm_irq_pkg;

    localparam int STATUS_W = 16;
    localparam int NUM_CNT  = 8;
    localparam int CNT_W    = 8;
    localparam int SEF_WIN  = 6;
    localparam int SEF_THR  = 2;
    localparam int ALIGN_W  = 8;
    localparam int ADDR_W   = 8;

    // Lower byte of the status word, most significant field first.
    typedef struct packed {
        logic tfs_chg;
        logic mfs_chg;
        logic fbe;
        logic cofa;
        logic sef;
        logic ais;
        logic crc;
        logic los;
    } evt_t;

    function automatic int unsigned ones_count(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += v[i] ? 1 : 0;
        end
        return n;
    endfunction

endpackage

// File: rtl/rx_alarm_wrap_bank.sv
module rx_alarm_wrap_bank
    import rx_alarm_irq_pkg::*;
#(
    parameter int N = NUM_CNT,
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] inc,
    output logic [N-1:0] wrap
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [W-1:0] shadow_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q <= '0;
            end else if (inc[g]) begin
                shadow_q <= shadow_q + 1'b1;
            end
        end

        assign wrap[g] = inc[g] && (shadow_q == TOP);
    end

endmodule

// File: rtl/rx_alarm_change_det.sv
module rx_alarm_change_det
    import rx_alarm_irq_pkg::*;
#(
    parameter int AW = ALIGN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tfs_lvl,
    input  logic          mfs_lvl,
    input  logic          reframe_done,
    input  logic [AW-1:0] new_align,
    output logic          tfs_chg,
    output logic          mfs_chg,
    output logic          cofa_evt
);

    logic          tfs_q;
    logic          mfs_q;
    logic [AW-1:0] align_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tfs_q   <= 1'b0;
            mfs_q   <= 1'b0;
            align_q <= '0;
        end else begin
            tfs_q <= tfs_lvl;
            mfs_q <= mfs_lvl;
            if (reframe_done) begin
                align_q <= new_align;
            end
        end
    end

    assign tfs_chg  = tfs_lvl ^ tfs_q;
    assign mfs_chg  = mfs_lvl ^ mfs_q;
    assign cofa_evt = reframe_done && (new_align != align_q);

endmodule

// File: rtl/rx_alarm_sef_window.sv
module rx_alarm_sef_window
    import rx_alarm_irq_pkg::*;
#(
    parameter int WIN = SEF_WIN,
    parameter int THR = SEF_THR
) (
    input  logic clk,
    input  logic rst,
    input  logic fbit_valid,
    input  logic fbit_err,
    output logic sef_evt
);

    localparam int HIST = WIN - 1;

    logic [HIST-1:0] hist_q;
    logic [WIN-1:0]  win_now;

    assign win_now = {hist_q, fbit_err};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (fbit_valid) begin
            hist_q <= win_now[HIST-1:0];
        end
    end

    assign sef_evt = fbit_valid && fbit_err &&
                     (ones_count(32'(win_now)) >= THR);

endmodule

// File: rtl/rx_alarm_irq_status.sv
module rx_alarm_irq_status
    import rx_alarm_irq_pkg::*;
#(
    parameter int          ADDR_W_P = ADDR_W,
    parameter logic [7:0]  ADDR_A   = 8'h34,
    parameter logic [7:0]  ADDR_B   = 8'h24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CNT-1:0]  cnt_inc,
    input  logic                tfs_lvl,
    input  logic                mfs_lvl,
    input  logic                fbit_valid,
    input  logic                fbit_err,
    input  logic                reframe_done,
    input  logic [ALIGN_W-1:0]  new_align,
    input  logic                ais_pulse,
    input  logic                crc_err_pulse,
    input  logic                los_pulse,
    input  logic [STATUS_W-1:0] irq_mask,
    input  logic                rd_en,
    input  logic [ADDR_W_P-1:0] rd_addr,
    output logic [STATUS_W-1:0] status,
    output logic                irq
);

    logic [NUM_CNT-1:0]  wrap;
    logic                tfs_chg;
    logic                mfs_chg;
    logic                cofa_evt;
    logic                sef_evt;
    evt_t                evt;
    logic [STATUS_W-1:0] raw;
    logic [STATUS_W-1:0] status_q;
    logic [STATUS_W-1:0] status_d;
    logic                clr_hit;

    rx_alarm_wrap_bank #(.N(NUM_CNT), .W(CNT_W)) u_wrap (
        .clk  (clk),
        .rst  (rst),
        .inc  (cnt_inc),
        .wrap (wrap)
    );

    rx_alarm_change_det #(.AW(ALIGN_W)) u_chg (
        .clk          (clk),
        .rst          (rst),
        .tfs_lvl      (tfs_lvl),
        .mfs_lvl      (mfs_lvl),
        .reframe_done (reframe_done),
        .new_align    (new_align),
        .tfs_chg      (tfs_chg),
        .mfs_chg      (mfs_chg),
        .cofa_evt     (cofa_evt)
    );

    rx_alarm_sef_window #(.WIN(SEF_WIN), .THR(SEF_THR)) u_sef (
        .clk        (clk),
        .rst        (rst),
        .fbit_valid (fbit_valid),
        .fbit_err   (fbit_err),
        .sef_evt    (sef_evt)
    );

    always_comb begin
        evt.tfs_chg = tfs_chg;
        evt.mfs_chg = mfs_chg;
        evt.fbe     = fbit_valid && fbit_err && tfs_lvl;
        evt.cofa    = cofa_evt;
        evt.sef     = sef_evt;
        evt.ais     = ais_pulse;
        evt.crc     = crc_err_pulse;
        evt.los     = los_pulse;
        raw         = {wrap, evt};
    end

    assign clr_hit = rd_en && ((rd_addr == ADDR_W_P'(ADDR_A)) ||
                               (rd_addr == ADDR_W_P'(ADDR_B)));

    // Clear first, then OR in this cycle's events so events win.
    always_comb begin
        status_d = clr_hit ? '0 : status_q;
        status_d = status_d | (raw & irq_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status = status_q;
    assign irq    = |status_q;

endmodule

// File: rtl/rx_alarm_irq_status_chk.sv
module rx_alarm_irq_status_chk
    import rx_alarm_irq_pkg::*;
#(
    parameter int          ADDR_W_P = ADDR_W,
    parameter logic [7:0]  ADDR_A   = 8'h34,
    parameter logic [7:0]  ADDR_B   = 8'h24
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_CNT-1:0]  cnt_inc,
    input logic                fbit_valid,
    input logic                fbit_err,
    input logic                reframe_done,
    input logic                los_pulse,
    input logic [STATUS_W-1:0] irq_mask,
    input logic                rd_en,
    input logic [ADDR_W_P-1:0] rd_addr,
    input logic [STATUS_W-1:0] status,
    input logic                irq
);

    logic clr_seen;
    assign clr_seen = rd_en && ((rd_addr == ADDR_W_P'(ADDR_A)) ||
                                (rd_addr == ADDR_W_P'(ADDR_B)));

    assert_wrap_src_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(status[15]) |-> $past(cnt_inc[7]));

    assert_wrap_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(status[8]) |-> $past(cnt_inc[0]));

    assert_cofa_src_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(status[4]) |-> $past(reframe_done));

    assert_sef_src_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(status[3]) |-> $past(fbit_valid && fbit_err));

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (status & ~$past(status) & ~$past(irq_mask)) == '0);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !clr_seen |=> ((status & $past(status)) == $past(status)));

    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_seen && irq_mask == '0) |=> (status == '0 && !irq));

    assert_event_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (clr_seen && los_pulse && irq_mask[0]) |=> (status[0] && irq));

endmodule

bind rx_alarm_irq_status rx_alarm_irq_status_chk #(
    .ADDR_W_P (ADDR_W_P),
    .ADDR_A   (ADDR_A),
    .ADDR_B   (ADDR_B)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cnt_inc      (cnt_inc),
    .fbit_valid   (fbit_valid),
    .fbit_err     (fbit_err),
    .reframe_done (reframe_done),
    .los_pulse    (los_pulse),
    .irq_mask     (irq_mask),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .status       (status),
    .irq          (irq)
);

// File: tb/rx_alarm_irq_status_bench.sv
`timescale 1ns/1ps
module rx_alarm_irq_status_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cnt_inc = '0;
    logic        tfs_lvl = 1'b0;
    logic        mfs_lvl = 1'b0;
    logic        fbit_valid = 1'b0;
    logic        fbit_err = 1'b0;
    logic        reframe_done = 1'b0;
    logic [7:0]  new_align = '0;
    logic        ais_pulse = 1'b0;
    logic        crc_err_pulse = 1'b0;
    logic        los_pulse = 1'b0;
    logic [15:0] irq_mask = 16'hFFFF;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] status;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rx_alarm_irq_status u_rx_alarm_irq_status (
        .clk(clk), .rst(rst), .cnt_inc(cnt_inc), .tfs_lvl(tfs_lvl),
        .mfs_lvl(mfs_lvl), .fbit_valid(fbit_valid), .fbit_err(fbit_err),
        .reframe_done(reframe_done), .new_align(new_align),
        .ais_pulse(ais_pulse), .crc_err_pulse(crc_err_pulse),
        .los_pulse(los_pulse), .irq_mask(irq_mask), .rd_en(rd_en),
        .rd_addr(rd_addr), .status(status), .irq(irq)
    );

    // {clear, ais, crc, los, mask[15:0], expected status[15:0]}
    localparam logic [35:0] VEC [8] = '{
        {1'b0, 3'b001, 16'hFFFF, 16'h0001},  // R7 los
        {1'b0, 3'b010, 16'hFFFF, 16'h0003},  // R7 crc
        {1'b0, 3'b100, 16'hFFFB, 16'h0003},  // R8 ais masked
        {1'b1, 3'b000, 16'hFFFF, 16'h0000},  // R10 clear
        {1'b1, 3'b101, 16'hFFFF, 16'h0005},  // R11 event beats clear
        {1'b0, 3'b000, 16'hFFFF, 16'h0005},  // R9 held
        {1'b0, 3'b010, 16'h0000, 16'h0005},  // R8 all masked
        {1'b1, 3'b000, 16'hFFFF, 16'h0000}   // R10 clear
    };

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Advance one edge, then drop all one-cycle strobes.
    task automatic step();
        @(posedge clk);
        #1;
        cnt_inc = '0; fbit_valid = 1'b0; fbit_err = 1'b0;
        reframe_done = 1'b0; ais_pulse = 1'b0; crc_err_pulse = 1'b0;
        los_pulse = 1'b0; rd_en = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a);
        rd_en = 1'b1; rd_addr = a;
        step();
    endtask

    task automatic fbit(input logic e);
        fbit_valid = 1'b1; fbit_err = e;
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        total++; fails++;
        $display("FAIL watchdog: got hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) step();
        check("R1 status in reset", status, 16'h0000);
        rst = 1'b0;
        step();
        check("R1 status after reset", status, 16'h0000);
        check("R1 irq after reset", {15'b0, irq}, 16'h0000);

        // Table walk: pulse sources, mask, clear and priority.
        for (int i = 0; i < 8; i++) begin
            irq_mask      = VEC[i][31:16];
            ais_pulse     = VEC[i][34];
            crc_err_pulse = VEC[i][33];
            los_pulse     = VEC[i][32];
            if (VEC[i][35]) begin
                rd_en = 1'b1; rd_addr = 8'h34;
            end
            step();
            check($sformatf("R7/R8/R9/R10/R11 vector %0d", i), status, VEC[i][15:0]);
        end

        // R12 irq follows the word
        irq_mask = 16'hFFFF; los_pulse = 1'b1; step();
        check("R12 irq set", {15'b0, irq}, 16'h0001);
        host_read(8'h24);
        check("R12 irq cleared", {15'b0, irq}, 16'h0000);

        // R2 counter wrap on framing-bit error counter (index 7)
        irq_mask = 16'h8000;
        for (int k = 0; k < 255; k++) begin
            cnt_inc = 8'h80; step();
        end
        check("R2 no flag before wrap", status, 16'h0000);
        cnt_inc = 8'h80; step();
        check("R2 flag on wrap idx7", status, 16'h8000);
        host_read(8'h34);
        irq_mask = 16'h0100;
        for (int k = 0; k < 256; k++) begin
            cnt_inc = 8'h01; step();
        end
        check("R2 flag on wrap idx0", status, 16'h0100);
        host_read(8'h34);
        irq_mask = 16'hBFFF;
        for (int k = 0; k < 256; k++) begin
            cnt_inc = 8'h40; step();
        end
        check("R8 masked wrap idx6", status, 16'h0000);

        // R3 sync level changes both ways
        irq_mask = 16'h00C0;
        tfs_lvl = 1'b1; step();
        check("R3 tfs rise", status, 16'h0080);
        host_read(8'h34);
        check("R3 steady level no event", status, 16'h0000);
        tfs_lvl = 1'b0; step();
        check("R3 tfs fall", status, 16'h0080);
        host_read(8'h34);
        mfs_lvl = 1'b1; step();
        check("R3 mfs rise", status, 16'h0040);
        host_read(8'h34);
        mfs_lvl = 1'b0; step();
        check("R3 mfs fall", status, 16'h0040);

        // R4 framing-bit error qualified by terminal sync
        irq_mask = 16'h0000; tfs_lvl = 1'b1; step(); host_read(8'h34);
        irq_mask = 16'h0020;
        fbit(1'b1);
        check("R4 fbe in sync", status, 16'h0020);
        irq_mask = 16'h0000; tfs_lvl = 1'b0; step(); host_read(8'h34);
        irq_mask = 16'h0020;
        fbit(1'b1);
        check("R4 fbe out of sync ignored", status, 16'h0000);

        // R6 two errors in six framing bits
        irq_mask = 16'h0008;
        for (int k = 0; k < 5; k++) fbit(1'b0);
        host_read(8'h34);
        fbit(1'b1);
        check("R6 single error", status, 16'h0000);
        for (int k = 0; k < 4; k++) fbit(1'b0);
        fbit(1'b1);
        check("R6 errors 5 apart in window", status, 16'h0008);
        host_read(8'h34);
        for (int k = 0; k < 5; k++) fbit(1'b0);
        fbit(1'b1);
        for (int k = 0; k < 5; k++) fbit(1'b0);
        fbit(1'b1);
        check("R6 errors 6 apart outside window", status, 16'h0000);

        // R5 change of frame alignment
        irq_mask = 16'h0010;
        new_align = 8'd5; reframe_done = 1'b1; step();
        check("R5 new alignment", status, 16'h0010);
        host_read(8'h34);
        new_align = 8'd5; reframe_done = 1'b1; step();
        check("R5 same alignment", status, 16'h0000);
        new_align = 8'd3; reframe_done = 1'b1; step();
        check("R5 changed again", status, 16'h0010);

        // R10 address decode
        host_read(8'h30);
        check("R10 other address keeps word", status, 16'h0010);
        host_read(8'h24);
        check("R10 alias address clears", status, 16'h0000);

        finish_run();
    end

endmodule